// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns the full 2*WIDTH-bit product, spending one clock cycle per multiplier bit. It trades throughput for area: a single WIDTH-bit adder and one 2*WIDTH-bit working register replace a full array of partial-product adders. It suits datapaths where multiplications are infrequent.

The multiplicand is captured in a WIDTH-bit holding register that stays untouched for the whole operation. The multiplier is captured into the lower half of the working register, and the upper half starts at zero. On every busy cycle the multiplicand is added to the upper half only if the working register's least significant bit is 1. The whole register then shifts right by one place, and the adder's carry-out enters at the top. After WIDTH such cycles the working register holds the product. A one-cycle `done_o` pulse marks the result, and the result stays on `product_o` until the next accepted start.

A selectable adder structure (behavioural sum or explicit ripple-carry chain) is fixed at elaboration through a parameter. Illegal parameter values stop elaboration.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is held and right after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` high at a clock edge while `busy_o` is 0 is accepted. After that edge `busy_o` is 1 and `product_o` equals the multiplier in bits [WIDTH-1:0] with bits [2*WIDTH-1:WIDTH] all zero.
- R3: Each busy cycle adds the multiplicand to the upper half only when bit 0 of `product_o` is 1, then shifts right by one with the carry-out as the new top bit. After k steps with multiplicand A and multiplier B, `product_o` = ((A * (B mod 2^k)) << (WIDTH-k)) + (B >> k). For WIDTH=4, 0111 times 0110 gives 0000_0011, 0011_1001, 0101_0100 and 0010_1010.
- R4: `busy_o` stays high for exactly WIDTH cycles after an accepted start. `done_o` is high for exactly one cycle, the cycle right after the last step, and `done_o` and `busy_o` are never both high.
- R5: When `done_o` is high, `product_o` equals the full unsigned 2*WIDTH-bit product A*B, including the all-ones by all-ones case.
- R6: A `start_i` pulse while `busy_o` is high is ignored. Operand inputs are sampled only at an accepted start, so changing them during an operation changes neither the result nor its timing.
- R7: From the `done_o` cycle until the next accepted start, `product_o` holds the finished product unchanged, whatever the operand inputs do.
- R8: A start presented in the same cycle that `done_o` is high is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | High while steps are in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Working register: loaded multiplier, partial state, then the product |

## Verification
The bench compares `product_o` after every single step against the closed-form partial value. A design that shifted before adding, or that dropped the carry instead of shifting it in at the top, therefore diverges on the first step that has a carry. All-ones operands exercise the carry on every step, and zero operands check that no stray add occurs. Start pulses and operand changes are driven throughout busy periods; a design that reloads on them would restart or finish with a wrong product. Back-to-back starts in the done cycle, and idle gaps with toggling operands, expose a design that drops the start or lets the held product drift.

// File: rtl/shamul_pkg.sv
package shamul_pkg;
   // Adder structure choices for the conditional add step
   localparam int ADD_BEHAV  = 0;
   localparam int ADD_RIPPLE = 1;

   function automatic bit adder_style_ok(input int style);
      return (style == ADD_BEHAV) || (style == ADD_RIPPLE);
   endfunction
endpackage

// File: rtl/shamul_adder.sv
module shamul_adder #(
   parameter int WIDTH = 8,
   parameter int STYLE = shamul_pkg::ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   generate
      if (STYLE == shamul_pkg::ADD_BEHAV) begin : g_behav
         logic [WIDTH:0] full;
         assign full   = {1'b0, a_i} + {1'b0, b_i};
         assign sum_o  = full[WIDTH-1:0];
         assign cout_o = full[WIDTH];
      end else begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
         end
         assign cout_o = carry[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/shamul_ctrl.sv
module shamul_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   logic [CNT_W-1:0] step_cnt;
   logic             busy_q;
   logic             done_q;

   assign load_o = start_i & ~busy_q;
   assign step_o = busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_cnt <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            step_cnt <= '0;
            busy_q   <= 1'b1;
         end else if (busy_q) begin
            step_cnt <= step_cnt + CNT_W'(1);
            if (step_cnt == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/shamul_datapath.sv
module shamul_datapath #(
   parameter int WIDTH = 8,
   parameter int STYLE = shamul_pkg::ADD_RIPPLE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               step_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   output logic [WIDTH-1:0]   mcand_o,
   output logic [2*WIDTH-1:0] work_o
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    work_q;
   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] upper_sum;
   logic             upper_cout;

   // Add the multiplicand only when the current low bit is set
   assign addend = work_q[0] ? mcand_q : '0;

   shamul_adder #(.WIDTH(WIDTH), .STYLE(STYLE)) u_add (
      .a_i    (work_q[PW-1:WIDTH]),
      .b_i    (addend),
      .sum_o  (upper_sum),
      .cout_o (upper_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         work_q  <= '0;
      end else if (load_i) begin
         mcand_q <= mcand_i;
         work_q  <= {{WIDTH{1'b0}}, mplier_i};
      end else if (step_i) begin
         work_q  <= {upper_cout, upper_sum, work_q[WIDTH-1:1]};
      end
   end

   assign mcand_o = mcand_q;
   assign work_o  = work_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
   parameter int WIDTH = 8,
   parameter int ADDER_STYLE = shamul_pkg::ADD_RIPPLE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [2*WIDTH-1:0] product_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shift_add_mult: WIDTH must be at least 2");
      end
      if (!shamul_pkg::adder_style_ok(ADDER_STYLE)) begin : g_bad_style
         $error("shift_add_mult: unsupported ADDER_STYLE");
      end
   endgenerate

   logic             load;
   logic             step;
   logic [WIDTH-1:0] mcand_q;

   shamul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   shamul_datapath #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .step_i   (step),
      .mcand_i  (mcand_i),
      .mplier_i (mplier_i),
      .mcand_o  (mcand_q),
      .work_o   (product_o)
   );
endmodule

// File: rtl/shamul_checker.sv
module shamul_checker #(
   parameter int WIDTH = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [WIDTH-1:0]   mplier_i,
   input logic               busy_o,
   input logic               done_o,
   input logic [2*WIDTH-1:0] product_o,
   input logic [WIDTH-1:0]   mcand_q
);
   localparam int CW = $clog2(WIDTH + 1) + 1;

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 busy_cnt <= '0;
      else if (start_i && !busy_o) busy_cnt <= '0;
      else if (busy_o)            busy_cnt <= busy_cnt + CW'(1);
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R4

   AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_cnt == CW'(WIDTH))); // R4

   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o)); // R4

   AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && product_o == {{WIDTH{1'b0}}, $past(mplier_i)})); // R2

   AST_SHIFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (product_o[WIDTH-2:0] == $past(product_o[WIDTH-1:1]))); // R3

   AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mcand_q)); // R6

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(product_o)); // R7
endmodule

bind shift_add_mult shamul_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .mplier_i  (mplier_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .product_o (product_o),
   .mcand_q   (mcand_q)
);

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb;
   localparam int W  = 8;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  a_in = '0;
   logic [W-1:0]  b_in = '0;
   logic          busy;
   logic          done;
   logic [PW-1:0] prod;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   logic [PW-1:0] held = '0;

   always #10 clk = ~clk; // 50 MHz

   shift_add_mult #(.WIDTH(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .mcand_i   (a_in),
      .mplier_i  (b_in),
      .busy_o    (busy),
      .done_o    (done),
      .product_o (prod)
   );

   task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Closed-form working register value after k steps
   function automatic logic [PW-1:0] trace_val(input logic [W-1:0] a, input logic [W-1:0] b, input int k);
      logic [PW-1:0] aw, bw, mask, part;
      aw   = PW'(a);
      bw   = PW'(b);
      mask = (PW'(1) << k) - PW'(1);
      part = aw * (bw & mask);
      return (part << (W - k)) + (bw >> k);
   endfunction

   function automatic logic [PW-1:0] full_prod(input logic [W-1:0] a, input logic [W-1:0] b);
      return PW'(a) * PW'(b);
   endfunction

   // Called at a negedge; returns at the negedge of the done cycle
   task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b, input bit junk, input bit b2b);
      start = 1'b1;
      a_in  = a;
      b_in  = b;
      @(negedge clk);
      check(b2b ? "R8 busy after back-to-back start" : "R2 busy after start", PW'(busy), PW'(1));
      check(b2b ? "R8 loaded register" : "R2 loaded register", prod, {{W{1'b0}}, b});
      for (int k = 1; k <= W; k++) begin
         start = junk;
         if (junk) begin
            a_in = W'($urandom);
            b_in = W'($urandom);
         end
         @(negedge clk);
         check("R3 step value", prod, trace_val(a, b, k));
         check("R4 busy level", PW'(busy), PW'(k < W));
         check("R4 done level", PW'(done), PW'(k == W));
      end
      start = 1'b0;
      check(junk ? "R6 result with ignored start" : "R5 product", prod, full_prod(a, b));
      held = prod;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         start = 1'b0;
         a_in  = W'($urandom);
         b_in  = W'($urandom);
         @(negedge clk);
         check("R7 product held", prod, held);
         check("R4 idle busy", PW'(busy), '0);
         check("R4 idle done", PW'(done), '0);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      start = 1'b1;
      a_in  = 8'hff;
      b_in  = 8'hff;
      repeat (3) @(negedge clk);
      check("R1 reset product", prod, '0);
      check("R1 reset busy", PW'(busy), '0);
      check("R1 reset done", PW'(done), '0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset product", prod, '0);
      check("R1 after reset busy", PW'(busy), '0);

      // Directed corners
      run_mult(8'd7,   8'd6,   1'b0, 1'b0); idle(2);
      run_mult(8'hff,  8'hff,  1'b0, 1'b0); idle(1);
      run_mult(8'h00,  8'hff,  1'b0, 1'b0); idle(1);
      run_mult(8'hff,  8'h00,  1'b1, 1'b0); idle(1);
      run_mult(8'h01,  8'hff,  1'b0, 1'b0);
      run_mult(8'h80,  8'h80,  1'b1, 1'b1); idle(3);
      run_mult(8'hff,  8'h01,  1'b1, 1'b0); idle(1);

      // Constrained random
      for (int n = 0; n < 60; n++) begin
         logic [W-1:0] ra, rb;
         bit jk, bb;
         ra = W'($urandom);
         rb = W'($urandom);
         jk = ($urandom % 2) == 0;
         bb = ($urandom % 3) == 0;
         run_mult(ra, rb, jk, 1'b0);
         if (!bb) idle(1 + ($urandom % 3));
         else begin
            run_mult(W'($urandom), W'($urandom), 1'b0, 1'b1);
            idle(1);
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule